// File: doc/BRIEF.md
# NAND Flash Host Bridge with Data-Path ECC

This block sits between a processor register bus and a raw NAND flash device whose data pins are byte-wide. It holds a small control register whose bits drive the flash command-latch, address-latch, chip-enable and write-protect pins. Reading that register also returns the live ready/busy level of the device. A data port turns bus writes into bytes sent to the device and bus reads into bytes taken from it. A 32-bit read of the port fetches two bytes in a row.

Each byte that crosses the data port, in either direction, is folded into a Hamming-style parity accumulator. The accumulator works over blocks of 256 bytes. Software reads back two line-parity registers, a column-parity register and a byte counter, and it can reset the accumulator by writing to a clear address. Correcting errors and sequencing flash commands are left to software.

The bus side uses a valid/ready request with a one-cycle `bus_done` completion pulse. `bus_ready` is high only while no access is in progress, and the requester holds its request until it sees `bus_ready`. The device side uses two byte streams, each with valid/ready. On the outgoing stream the block holds `fl_wr_valid` and `fl_wr_data` steady until `fl_wr_ready` is seen. On the incoming stream the block raises `fl_rd_ready` only while it is waiting for a byte.

Top module: `nand_host_if`

## Requirements
- R1: After reset the control register is zero, so `fl_ce`, `fl_cle`, `fl_ale` and `fl_wp` are low. The accumulator is zero, so the registers at 0x00, 0x04, 0x08 and 0x0C read 0. `bus_ready` is high and `bus_done` is low.
- R2: A write to offset 0x18 stores `bus_wdata` with bit 5 forced to 0. A read of 0x18 returns the stored bits, with bit 5 replaced by the level of `fl_rb`. Field layout: bit0 enable A, bit1 command latch, bit2 address latch, bit3 write protect, bit4 enable B, bit5 ready/busy.
- R3: `fl_ce` is the OR of control bits 0 and 4. `fl_cle`, `fl_ale` and `fl_wp` follow bits 1, 2 and 3. All four change in the cycle after the accepted control write.
- R4: Within the 64-byte window, only offsets 0x00, 0x04, 0x08, 0x0C, 0x14 and 0x18 return data. Every other offset, including 0x10, reads as 0. A write to any offset other than 0x10, 0x14 or 0x18 changes no pin and no accumulator state.
- R5: A write to 0x14 sends the low byte of `bus_wdata` on `fl_wr_data`. `fl_wr_valid` and the byte stay unchanged until `fl_wr_ready` is seen. `bus_ready` stays low until the byte is taken, and `bus_done` pulses in the cycle after the taking edge. The block never asks for an outgoing byte and an incoming byte at the same time.
- R6: A byte read of 0x14 takes one byte from the device and returns it zero-extended. A 32-bit read (`bus_word`=1) takes two bytes: the first appears zero-extended in bits 15:0 and the second zero-extended in bits 31:16.
- R7: Every byte that crosses the data port, in either direction, advances the byte counter by one. Offset 0x0C reads the counter modulo 256.
- R8: Line parity has 16 bits. For byte index n (the counter value before the byte, modulo 256) and address bit k, the parity of the byte is XORed into bit 2k when bit k of n is 0, and into bit 2k+1 when it is 1. Parity byte 0 holds bits 7:0 and parity byte 1 holds bits 15:8.
- R9: Offset 0x00 places bits 0..3 of parity byte 0 at register bits 0,2,4,6 and bits 0..3 of parity byte 1 at bits 1,3,5,7. Offset 0x04 does the same with bits 4..7 of each byte.
- R10: Offset 0x08 returns six column-parity bits computed from the XOR of all bytes, C. Bit0 is the parity of C&0x55, bit1 of C&0xAA, bit2 of C&0x33, bit3 of C&0xCC, bit4 of C&0x0F and bit5 of C&0xF0.
- R11: Any write to offset 0x10, whatever its data, clears the counter and the line and column parity.
- R12: Any access to an offset other than 0x14 is accepted while `bus_ready` is high and completes with `bus_done` in the next cycle, with read data valid while `bus_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Block idle, request accepted this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_word | input | 1 | 32-bit access; two bytes on a data-port read |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_done |
| fl_wr_valid | output | 1 | Outgoing byte present |
| fl_wr_ready | input | 1 | Device takes outgoing byte |
| fl_wr_data | output | 8 | Outgoing byte |
| fl_rd_valid | input | 1 | Incoming byte present |
| fl_rd_ready | output | 1 | Block waiting for an incoming byte |
| fl_rd_data | input | 8 | Incoming byte |
| fl_ce | output | 1 | Chip enable (active high) |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_wp | output | 1 | Write protect |
| fl_rb | input | 1 | Device ready/busy level |

## Verification
The hardest state to reach from the ports is a byte counter that has wrapped past 256, so that byte indices are reused, while the device is stalling the outgoing stream. To get there, the stimulus pushes 300 writes through the data port with a device model that accepts only one cycle in three. A bench-side parity model tracks every byte taken at the device handshake, and its result is compared with the interleaved line-parity registers. A two-byte word read is then run against a device that offers data only every other cycle, which checks lane placement and ECC ordering across a gap. Hand-computed parities for a two-byte sequence after a clear pin down the bit interleave on their own.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  localparam int WIN_AW = 6;

  localparam logic [WIN_AW-1:0] OFS_LPA  = 6'h00;
  localparam logic [WIN_AW-1:0] OFS_LPB  = 6'h04;
  localparam logic [WIN_AW-1:0] OFS_CP   = 6'h08;
  localparam logic [WIN_AW-1:0] OFS_CNT  = 6'h0C;
  localparam logic [WIN_AW-1:0] OFS_CLR  = 6'h10;
  localparam logic [WIN_AW-1:0] OFS_DATA = 6'h14;
  localparam logic [WIN_AW-1:0] OFS_CTL  = 6'h18;

  localparam int CB_CE0 = 0;
  localparam int CB_CLE = 1;
  localparam int CB_ALE = 2;
  localparam int CB_WP  = 3;
  localparam int CB_CE1 = 4;
  localparam int CB_RB  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/nand_ctl_reg.sv
module nand_ctl_reg
  import nand_host_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             rb_pin,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             pin_ce,
  output logic             pin_cle,
  output logic             pin_ale,
  output logic             pin_wp
);
  localparam logic [CTL_W-1:0] RO_MASK = CTL_W'(1) << CB_RB;

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data & ~RO_MASK;
  end

  assign ctl_rd  = ctl_q | (rb_pin ? RO_MASK : '0);
  assign pin_ce  = ctl_q[CB_CE0] | ctl_q[CB_CE1];
  assign pin_cle = ctl_q[CB_CLE];
  assign pin_ale = ctl_q[CB_ALE];
  assign pin_wp  = ctl_q[CB_WP];
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 256,
  localparam int IDX_W    = $clog2(BLK_BYTES),
  localparam int LP_W     = 2 * IDX_W,
  localparam int CP_W     = 2 * $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [LP_W-1:0]   lp_o,
  output logic [CP_W-1:0]   cp_o,
  output logic [IDX_W-1:0]  cnt_o
);
  localparam int GRP = $clog2(DATA_W);

  logic [LP_W-1:0]   lp_q, lp_nxt;
  logic [DATA_W-1:0] col_q;
  logic [IDX_W-1:0]  cnt_q;

  // Byte parity lands in the even or odd slot of each address bit.
  always_comb begin
    lp_nxt = lp_q;
    if (^din) begin
      for (int k = 0; k < IDX_W; k++) begin
        lp_nxt[2*k + int'(cnt_q[k])] = ~lp_q[2*k + int'(cnt_q[k])];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= '0;
      col_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      lp_q  <= '0;
      col_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      lp_q  <= lp_nxt;
      col_q <= col_q ^ din;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Column parity: per bit-group g, split data bits by bit g of their index.
  always_comb begin
    cp_o = '0;
    for (int g = 0; g < GRP; g++) begin
      for (int b = 0; b < DATA_W; b++) begin
        cp_o[2*g + ((b >> g) & 1)] = cp_o[2*g + ((b >> g) & 1)] ^ col_q[b];
      end
    end
  end

  assign lp_o  = lp_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/nand_port_seq.sv
module nand_port_seq
  import nand_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RD_W  = 4 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_data_port,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [RD_W-1:0]   reg_rdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [RD_W-1:0]   rsp_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ecc_upd,
  output logic [DATA_W-1:0] ecc_byte
);
  localparam int LANE_W = 2 * DATA_W;

  seq_st_e           st_q;
  logic [DATA_W-1:0] wbyte_q;
  logic              two_q, second_q, done_q;
  logic [RD_W-1:0]   rdata_q;
  logic              accept;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wbyte_q  <= '0;
      two_q    <= 1'b0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (req_data_port && req_we) begin
            wbyte_q <= req_wdata;
            st_q    <= ST_WR;
          end else if (req_data_port) begin
            two_q    <= req_word;
            second_q <= 1'b0;
            rdata_q  <= '0;
            st_q     <= ST_RD;
          end else begin
            rdata_q <= reg_rdata;
            done_q  <= 1'b1;
          end
        end
        ST_WR: if (wr_ready) begin
          rdata_q <= '0;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        ST_RD: if (rd_valid) begin
          if (!second_q) rdata_q[LANE_W-1:0]    <= LANE_W'(rd_data);
          else           rdata_q[RD_W-1:LANE_W] <= LANE_W'(rd_data);
          if (two_q && !second_q) begin
            second_q <= 1'b1;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid  = (st_q == ST_WR);
  assign wr_data   = wbyte_q;
  assign rd_ready  = (st_q == ST_RD);
  assign ecc_upd   = (wr_valid && wr_ready) || (rd_ready && rd_valid);
  assign ecc_byte  = wr_valid ? wbyte_q : rd_data;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nand_host_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_word,
  output logic              bus_done,
  output logic [4*DATA_W-1:0] bus_rdata,
  output logic              fl_wr_valid,
  input  logic              fl_wr_ready,
  output logic [DATA_W-1:0] fl_wr_data,
  input  logic              fl_rd_valid,
  output logic              fl_rd_ready,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              fl_ce,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_wp,
  input  logic              fl_rb
);
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam int LP_W  = 2 * IDX_W;
  localparam int CP_W  = 2 * $clog2(DATA_W);
  localparam int HALF  = IDX_W / 2;
  localparam int RD_W  = 4 * DATA_W;

  logic              accept, ctl_we, ecc_clr, hit_data;
  logic              ecc_upd;
  logic [DATA_W-1:0] ecc_byte, ctl_rd;
  logic [LP_W-1:0]   ecc_lp;
  logic [CP_W-1:0]   ecc_cp;
  logic [IDX_W-1:0]  ecc_cnt;
  logic [IDX_W-1:0]  lpa_v, lpb_v;
  logic [RD_W-1:0]   reg_rdata;

  assign accept   = bus_valid && bus_ready;
  assign hit_data = (bus_addr == OFS_DATA);
  assign ctl_we   = accept && bus_we && (bus_addr == OFS_CTL);
  assign ecc_clr  = accept && bus_we && (bus_addr == OFS_CLR);

  nand_ctl_reg #(.CTL_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_data(bus_wdata),
    .rb_pin(fl_rb), .ctl_rd(ctl_rd), .pin_ce(fl_ce), .pin_cle(fl_cle),
    .pin_ale(fl_ale), .pin_wp(fl_wp)
  );

  nand_ecc_acc #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)) u_ecc (
    .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .upd(ecc_upd), .din(ecc_byte),
    .lp_o(ecc_lp), .cp_o(ecc_cp), .cnt_o(ecc_cnt)
  );

  nand_port_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(bus_valid), .req_we(bus_we),
    .req_data_port(hit_data), .req_word(bus_word), .req_wdata(bus_wdata),
    .reg_rdata(reg_rdata), .req_ready(bus_ready), .rsp_done(bus_done),
    .rsp_rdata(bus_rdata), .wr_valid(fl_wr_valid), .wr_ready(fl_wr_ready),
    .wr_data(fl_wr_data), .rd_valid(fl_rd_valid), .rd_ready(fl_rd_ready),
    .rd_data(fl_rd_data), .ecc_upd(ecc_upd), .ecc_byte(ecc_byte)
  );

  // Bit interleave of the two parity bytes: low nibbles at 0x00, high at 0x04.
  for (genvar i = 0; i < HALF; i++) begin : g_ilv
    assign lpa_v[2*i]   = ecc_lp[i];
    assign lpa_v[2*i+1] = ecc_lp[IDX_W + i];
    assign lpb_v[2*i]   = ecc_lp[HALF + i];
    assign lpb_v[2*i+1] = ecc_lp[IDX_W + HALF + i];
  end

  always_comb begin
    unique case (bus_addr)
      OFS_LPA: reg_rdata = RD_W'(lpa_v);
      OFS_LPB: reg_rdata = RD_W'(lpb_v);
      OFS_CP:  reg_rdata = RD_W'(ecc_cp);
      OFS_CNT: reg_rdata = RD_W'(ecc_cnt);
      OFS_CTL: reg_rdata = RD_W'(ctl_rd);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_host_if_chk.sv
module nand_host_if_chk
  import nand_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [WIN_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_done,
  input logic              fl_wr_valid,
  input logic              fl_wr_ready,
  input logic [DATA_W-1:0] fl_wr_data,
  input logic              fl_rd_valid,
  input logic              fl_rd_ready,
  input logic              fl_ce,
  input logic              fl_cle,
  input logic              fl_ale,
  input logic              fl_wp,
  input logic [IDX_W-1:0]  ecc_cnt,
  input logic [2*IDX_W-1:0] ecc_lp
);
  logic acc, no_side;
  assign acc     = bus_valid && bus_ready;
  assign no_side = (bus_addr != OFS_CTL) && (bus_addr != OFS_CLR) && (bus_addr != OFS_DATA);

  AST_PINS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_we && bus_addr == OFS_CTL) |=>
      (fl_ce == ($past(bus_wdata[CB_CE0]) || $past(bus_wdata[CB_CE1]))) &&
      (fl_cle == $past(bus_wdata[CB_CLE])) && (fl_wp == $past(bus_wdata[CB_WP]))); // R3

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr_valid && !fl_wr_ready) |=> (fl_wr_valid && $stable(fl_wr_data))); // R5

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr_valid && fl_rd_ready)); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_wr_valid && fl_wr_ready) || (fl_rd_valid && fl_rd_ready)) |=>
      (ecc_cnt == $past(ecc_cnt) + 1'b1)); // R7

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_we && bus_addr == OFS_CLR) |=> (ecc_cnt == '0 && ecc_lp == '0)); // R11

  AST_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_we && no_side) |=>
      ($stable({fl_ce, fl_cle, fl_ale, fl_wp}) && ecc_cnt == $past(ecc_cnt))); // R4

  AST_REG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_addr != OFS_DATA) |=> (bus_done && bus_ready)); // R12
endmodule

bind nand_host_if nand_host_if_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
  .fl_wr_valid(fl_wr_valid), .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data),
  .fl_rd_valid(fl_rd_valid), .fl_rd_ready(fl_rd_ready), .fl_ce(fl_ce),
  .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_wp(fl_wp), .ecc_cnt(ecc_cnt), .ecc_lp(ecc_lp)
);

// File: tb/nand_host_if_tb.sv
module nand_host_if_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ready, bus_done;
  logic [31:0] bus_rdata;
  logic        fl_wr_valid, fl_wr_ready = 1'b0;
  logic [7:0]  fl_wr_data;
  logic        fl_rd_valid = 1'b0, fl_rd_ready;
  logic [7:0]  fl_rd_data = '0;
  logic        fl_ce, fl_cle, fl_ale, fl_wp;
  logic        fl_rb = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_word(bus_word),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .fl_wr_valid(fl_wr_valid),
    .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data), .fl_rd_valid(fl_rd_valid),
    .fl_rd_ready(fl_rd_ready), .fl_rd_data(fl_rd_data), .fl_ce(fl_ce), .fl_cle(fl_cle),
    .fl_ale(fl_ale), .fl_wp(fl_wp), .fl_rb(fl_rb)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Parity reference built from the requirement text.
  logic [15:0] m_lp = '0;
  logic [7:0]  m_col = '0;
  int          m_cnt = 0;

  function automatic void model_byte(input logic [7:0] b);
    int idx;
    idx = m_cnt % 256;
    if (^b) begin
      for (int k = 0; k < 8; k++) begin
        if ((idx >> k) & 1) m_lp[2*k+1] = ~m_lp[2*k+1];
        else                m_lp[2*k]   = ~m_lp[2*k];
      end
    end
    m_col = m_col ^ b;
    m_cnt++;
  endfunction

  function automatic void model_clear();
    m_lp = '0; m_col = '0; m_cnt = 0;
  endfunction

  function automatic logic [31:0] exp_lpa();
    return {24'h0, m_lp[11], m_lp[3], m_lp[10], m_lp[2], m_lp[9], m_lp[1], m_lp[8], m_lp[0]};
  endfunction
  function automatic logic [31:0] exp_lpb();
    return {24'h0, m_lp[15], m_lp[7], m_lp[14], m_lp[6], m_lp[13], m_lp[5], m_lp[12], m_lp[4]};
  endfunction
  function automatic logic [31:0] exp_cp();
    return {26'h0, ^(m_col & 8'hF0), ^(m_col & 8'h0F), ^(m_col & 8'hCC),
            ^(m_col & 8'h33), ^(m_col & 8'hAA), ^(m_col & 8'h55)};
  endfunction

  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction
  function automatic logic [7:0] wr_byte(input int i);
    return 8'(((i * 53 + 11) ^ (i >> 3)) & 255);
  endfunction

  // Device model: both streams driven at the falling edge.
  int         cyc = 0, wr_period = 1, rd_period = 1, src_idx = 0, snk_cnt = 0;
  logic [7:0] snk_last = '0, held = '0;
  logic       hold_pend = 1'b0;

  always @(negedge clk) begin
    logic r, v;
    cyc++;
    if (hold_pend) begin
      check("R5 held valid", {31'h0, fl_wr_valid}, 32'h1);
      check("R5 held byte", {24'h0, fl_wr_data}, {24'h0, held});
    end
    if (fl_wr_valid) check("R5 bus_ready low during write", {31'h0, bus_ready}, 32'h0);
    r = (cyc % wr_period) == 0;
    fl_wr_ready = r;
    hold_pend = fl_wr_valid && !r;
    held = fl_wr_data;
    if (fl_wr_valid && r) begin
      snk_last = fl_wr_data;
      snk_cnt++;
      model_byte(fl_wr_data);
    end
    v = (cyc % rd_period) == 0;
    fl_rd_data = src_byte(src_idx);
    fl_rd_valid = v;
    if (v && fl_rd_ready) begin
      model_byte(fl_rd_data);
      src_idx++;
    end
  end

  task automatic bus_op(input logic we, input logic [5:0] a, input logic [7:0] d,
                        input logic w, output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_word = w;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    lat = 1;
    while (!bus_done) begin
      @(negedge clk);
      lat++;
    end
    rd = bus_rdata;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] rd);
    int lat;
    bus_op(1'b0, a, 8'h00, 1'b0, rd, lat);
  endtask
  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    logic [31:0] rd;
    int lat;
    bus_op(1'b1, a, d, 1'b0, rd, lat);
  endtask

  typedef struct packed {
    logic [7:0] wr;
    logic       rb;
    logic [7:0] exp_rd;
    logic [3:0] pins;   // {ce, cle, ale, wp}
  } ctl_vec_t;

  localparam ctl_vec_t VEC [9] = '{
    '{8'h01, 1'b1, 8'h21, 4'b1000},
    '{8'h10, 1'b0, 8'h10, 4'b1000},
    '{8'h02, 1'b0, 8'h02, 4'b0100},
    '{8'h04, 1'b1, 8'h24, 4'b0010},
    '{8'h08, 1'b0, 8'h08, 4'b0001},
    '{8'hFF, 1'b0, 8'hDF, 4'b1111},
    '{8'h20, 1'b0, 8'h00, 4'b0000},
    '{8'h3F, 1'b1, 8'h3F, 4'b1111},
    '{8'h11, 1'b0, 8'h11, 4'b1000}
  };

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, base;
    logic [31:0] exp_w;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pins", {28'h0, fl_ce, fl_cle, fl_ale, fl_wp}, 32'h0);
    check("R1 bus_ready", {31'h0, bus_ready}, 32'h1);
    check("R1 bus_done", {31'h0, bus_done}, 32'h0);
    rst_n = 1'b1;
    rd_reg(6'h00, rd); check("R1 lpa", rd, 32'h0);
    rd_reg(6'h04, rd); check("R1 lpb", rd, 32'h0);
    rd_reg(6'h08, rd); check("R1 cp", rd, 32'h0);
    rd_reg(6'h0C, rd); check("R1 cnt", rd, 32'h0);
    rd_reg(6'h18, rd); check("R1 ctl with rb=1", rd, 32'h20);

    // R2/R3: control register table
    foreach (VEC[i]) begin
      @(negedge clk); fl_rb = VEC[i].rb;
      wr_reg(6'h18, VEC[i].wr);
      check("R3 pins", {28'h0, fl_ce, fl_cle, fl_ale, fl_wp}, {28'h0, VEC[i].pins});
      rd_reg(6'h18, rd);
      check("R2 ctl readback", rd, {24'h0, VEC[i].exp_rd});
    end

    // R12: register access latency
    bus_op(1'b0, 6'h0C, 8'h00, 1'b0, rd, lat);
    check("R12 done one cycle after accept", 32'(lat), 32'd1);

    // R5/R7/R8/R9/R10: 300 writes with a stalling device, counter wraps
    wr_period = 3;
    for (int i = 0; i < 300; i++) begin
      wr_reg(6'h14, wr_byte(i));
      check("R5 byte at device", {24'h0, snk_last}, {24'h0, wr_byte(i)});
    end
    wr_period = 1;
    check("R5 byte count at device", 32'(snk_cnt), 32'd300);
    rd_reg(6'h0C, rd); check("R7 cnt wraps mod 256", rd, 32'd44);
    rd_reg(6'h00, rd); check("R9 lpa after burst", rd, exp_lpa());
    rd_reg(6'h04, rd); check("R9 lpb after burst", rd, exp_lpb());
    rd_reg(6'h08, rd); check("R10 cp after burst", rd, exp_cp());

    // R11: clear with nonzero data
    wr_reg(6'h10, 8'hA5); model_clear();
    rd_reg(6'h0C, rd); check("R11 cnt cleared", rd, 32'h0);
    rd_reg(6'h00, rd); check("R11 lpa cleared", rd, 32'h0);
    rd_reg(6'h04, rd); check("R11 lpb cleared", rd, 32'h0);
    rd_reg(6'h08, rd); check("R11 cp cleared", rd, 32'h0);

    // R8/R9/R10: hand-computed two-byte case
    wr_reg(6'h14, 8'h01);
    rd_reg(6'h00, rd); check("R8 lpa after 0x01", rd, 32'h33);
    rd_reg(6'h04, rd); check("R8 lpb after 0x01", rd, 32'h33);
    rd_reg(6'h08, rd); check("R10 cp after 0x01", rd, 32'h15);
    wr_reg(6'h14, 8'h03);
    rd_reg(6'h08, rd); check("R10 cp after 0x03", rd, 32'h16);
    rd_reg(6'h00, rd); check("R8 even-parity byte leaves lpa", rd, 32'h33);
    rd_reg(6'h0C, rd); check("R7 cnt after two", rd, 32'd2);

    // R6: word read with gaps, then byte read
    wr_reg(6'h10, 8'h00); model_clear();
    rd_period = 2;
    base = src_idx;
    exp_w = {8'h0, src_byte(base + 1), 8'h0, src_byte(base)};
    bus_op(1'b0, 6'h14, 8'h00, 1'b1, rd, lat);
    check("R6 word read lanes", rd, exp_w);
    base = src_idx;
    bus_op(1'b0, 6'h14, 8'h00, 1'b0, rd, lat);
    check("R6 byte read", rd, {24'h0, src_byte(base)});
    rd_period = 1;
    rd_reg(6'h0C, rd); check("R7 cnt after reads", rd, 32'd3);
    rd_reg(6'h00, rd); check("R9 lpa after reads", rd, exp_lpa());
    rd_reg(6'h04, rd); check("R9 lpb after reads", rd, exp_lpb());
    rd_reg(6'h08, rd); check("R10 cp after reads", rd, exp_cp());

    // R4: unmapped offsets
    wr_reg(6'h18, 8'h06);
    rd_reg(6'h1C, rd); check("R4 read 0x1C", rd, 32'h0);
    rd_reg(6'h3C, rd); check("R4 read 0x3C", rd, 32'h0);
    rd_reg(6'h02, rd); check("R4 read 0x02", rd, 32'h0);
    rd_reg(6'h10, rd); check("R4 read clear offset", rd, 32'h0);
    wr_reg(6'h20, 8'hFF);
    wr_reg(6'h3C, 8'hFF);
    wr_reg(6'h0C, 8'hFF);
    check("R4 pins unchanged", {28'h0, fl_ce, fl_cle, fl_ale, fl_wp}, 32'b0110);
    rd_reg(6'h0C, rd); check("R4 cnt unchanged", rd, 32'd3);
    rd_reg(6'h08, rd); check("R4 cp unchanged", rd, exp_cp());

    summary();
    $finish;
  end
endmodule